// File: doc/BRIEF.md
# Symmetric Phase-Level Sequencer for a Three-Level Clamped Inverter

This block turns one modulation period's worth of switching decisions into six gate signals for a three-phase, three-level neutral-clamped inverter. Upstream logic picks the triangle of the space-vector plane that holds the reference. It hands over an ordered chain of phase-level triplets for that triangle, a tag that ties each triplet to one of three vectors, and the total on-time of each vector. The sequencer runs a free-running period counter. Within each period it plays the chain forward and then backward, so the period starts and ends on the same triplet. Each vector's on-time is shared out evenly over all the slots that realise that vector.

Every phase level is decoded into the two commutation-cell gate signals of its leg. A chain in which each step moves one phase by one level therefore commutes every switch at most once on the way out and once on the way back. This keeps the switching frequency fixed. The inputs are sampled only at the period boundary, so a new triangle never cuts into a running period. A check flag reports any chain that breaks the one-phase, one-level stepping rule.

Top module: `sps_sequencer`

## Requirements
- R1: While reset is asserted, and for the whole first period after it is released, all six gate outputs and `seq_err` are low.
- R2: Triplet i sits at `tri_list[6i+5:6i]`, and phase p (a=0, b=1, c=2) of a triplet sits at bits [2p+1:2p] of it. Phase p drives `gate[2p+1]` (outer cell) and `gate[2p]` (inner cell). Level 0 gives 00, level 1 gives 01 (inner cell only), and level 2 gives 11.
- R3: A period holds 2N-1 slots. Slot j plays triplet j for j < N and triplet 2N-2-j for j >= N. The sequence therefore runs forward to the last triplet and back to the first.
- R4: The tag of triplet i is `vec_tag[2i+1:2i]`, and tag value v (0 to 2) selects the on-time `on_time[TW*v+TW-1:TW*v]`. A vector's slot count is the number of slots in the sequence that play a triplet carrying its tag. Each of those slots lasts floor(on-time / slot count) cycles.
- R5: Slots follow each other from cycle 0 of the period, which is PERIOD cycles long. The last slot extends to the end of the period. Any slot that would start at or after the period end is not played, and zero-length slots are skipped.
- R6: `tri_list`, `vec_tag` and `on_time` are sampled only on the final cycle of a period and take effect from the next cycle 0. Changes at any other time have no effect on the outputs.
- R7: `seq_err` is high for a whole period when the chain sampled for it has any of the following faults: a pair of neighbouring triplets that does not differ in exactly one phase by exactly one level, a level code of 3, or a tag of 3. Otherwise it is low.
- R8: With a valid chain, no zero-length slots and on-times that fit in the period, every output change within a period moves one leg by one level. The period boundary adds no commutation when the chain is unchanged, so a four-triplet chain toggles exactly six gate bits per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tri_list | input | 6*N_STATES | Ordered chain of phase-level triplets |
| vec_tag | input | 2*N_STATES | Vector tag of each triplet |
| on_time | input | 3*TW | Total on-time of each vector, in cycles |
| gate | output | 6 | Commutation-cell gate signals, two per leg |
| seq_err | output | 1 | Chain of the current period breaks the stepping rule |

## Verification
The assertions check four properties on every cycle: the period counter stays in range, the sampled chain changes only at the period boundary, `seq_err` holds steady within a period, and a valid chain without empty slots moves one leg by one level per change and closes the period on its first triplet. Only the bench scenarios can show the actual slot lengths: the floor division per vector, the long last slot, truncation when the on-times overrun the period, and the exact gate codes per level. The same holds for the first period after reset staying dark and for a mid-period input change being ignored until the boundary.

// File: rtl/sps_pkg.sv
package sps_pkg;

   localparam int PH     = 3;
   localparam int TRIP_W = 2 * PH;

   typedef logic [1:0] lvl_t;

   // {outer, inner}: level 0 -> 00, level 1 -> 01, level 2 -> 11
   function automatic logic [1:0] lvl_to_gates(input lvl_t l);
      return {l[1], |l};
   endfunction

   // Exactly one phase moves, and by exactly one level
   function automatic logic one_step(input logic [TRIP_W-1:0] x,
                                     input logic [TRIP_W-1:0] y);
      int nd;
      logic bad;
      nd  = 0;
      bad = 1'b0;
      for (int p = 0; p < PH; p++) begin
         int d;
         d = int'(x[2*p +: 2]) - int'(y[2*p +: 2]);
         if (d != 0) nd++;
         if (d > 1 || d < -1) bad = 1'b1;
      end
      return (nd == 1) && !bad;
   endfunction

   function automatic logic has_bad_code(input logic [TRIP_W-1:0] x);
      logic b;
      b = 1'b0;
      for (int p = 0; p < PH; p++)
         if (x[2*p +: 2] == 2'b11) b = 1'b1;
      return b;
   endfunction

endpackage

// File: rtl/sps_period_timer.sv
module sps_period_timer #(
   parameter int PERIOD = 2500,
   parameter int CW     = $clog2(PERIOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt,
   output logic          wrap
);

   assign wrap = (cnt == CW'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < PERIOD); // R5

endmodule

// File: rtl/sps_slot_plan.sv
module sps_slot_plan #(
   parameter int N_STATES = 4,
   parameter int TW       = 12,
   parameter int SW       = TW + $clog2(2 * N_STATES)
) (
   input  logic [N_STATES*sps_pkg::TRIP_W-1:0] tri_list,
   input  logic [N_STATES*2-1:0]               vec_tag,
   input  logic [3*TW-1:0]                     on_time,
   output logic [(2*N_STATES-2)*SW-1:0]        cum_flat,
   output logic                                plan_err,
   output logic                                has_empty
);
   import sps_pkg::*;

   localparam int NSLOT = 2 * N_STATES - 1;
   localparam int NB    = NSLOT - 1;
   localparam int MW    = $clog2(2 * N_STATES);

   logic [MW-1:0] mult [3];
   logic [TW-1:0] dur  [N_STATES];

   // slot count per vector: the outermost triplet plays once, all others twice
   always_comb begin
      for (int v = 0; v < 3; v++) begin
         mult[v] = '0;
         for (int i = 0; i < N_STATES; i++)
            if (int'(vec_tag[2*i +: 2]) == v)
               mult[v] = mult[v] + ((i == N_STATES - 1) ? MW'(1) : MW'(2));
      end
   end

   always_comb begin
      for (int i = 0; i < N_STATES; i++) begin
         int tg;
         tg = int'(vec_tag[2*i +: 2]);
         if (tg < 3 && mult[tg] != '0)
            dur[i] = on_time[TW*tg +: TW] / TW'(mult[tg]);
         else
            dur[i] = '0;
      end
   end

   // cumulative slot ends; the last slot needs none
   always_comb begin
      logic [SW-1:0] acc;
      acc      = '0;
      cum_flat = '0;
      for (int k = 0; k < NB; k++) begin
         int st;
         st  = (k < N_STATES) ? k : (2 * N_STATES - 2 - k);
         acc = acc + SW'(dur[st]);
         cum_flat[k*SW +: SW] = acc;
      end
   end

   always_comb begin
      plan_err  = 1'b0;
      has_empty = 1'b0;
      for (int i = 0; i < N_STATES; i++) begin
         if (has_bad_code(tri_list[TRIP_W*i +: TRIP_W])) plan_err = 1'b1;
         if (vec_tag[2*i +: 2] == 2'b11)                 plan_err = 1'b1;
         if (dur[i] == '0)                               has_empty = 1'b1;
      end
      for (int i = 0; i < N_STATES - 1; i++)
         if (!one_step(tri_list[TRIP_W*i +: TRIP_W], tri_list[TRIP_W*(i+1) +: TRIP_W]))
            plan_err = 1'b1;
   end

endmodule

// File: rtl/sps_leg_map.sv
module sps_leg_map #(
   parameter int NPH = 3
) (
   input  logic [2*NPH-1:0] level,
   output logic [2*NPH-1:0] gate
);
   for (genvar p = 0; p < NPH; p++) begin : g_leg
      assign gate[2*p +: 2] = sps_pkg::lvl_to_gates(level[2*p +: 2]);
   end
endmodule

// File: rtl/sps_sequencer.sv
module sps_sequencer #(
   parameter int N_STATES = 4,
   parameter int TW       = 12,
   parameter int PERIOD   = 2500
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_STATES*6-1:0]    tri_list,
   input  logic [N_STATES*2-1:0]    vec_tag,
   input  logic [3*TW-1:0]          on_time,
   output logic [5:0]               gate,
   output logic                     seq_err
);
   import sps_pkg::*;

   localparam int NSLOT = 2 * N_STATES - 1;
   localparam int NB    = NSLOT - 1;
   localparam int CW    = $clog2(PERIOD);
   localparam int SW    = TW + $clog2(2 * N_STATES);
   localparam int CMPW  = (CW > SW) ? CW : SW;
   localparam int SELW  = $clog2(NSLOT);

   if (N_STATES < 2 || N_STATES > 8) begin : g_chk_n
      $error("N_STATES must lie in 2..8");
   end
   if (PERIOD < 2) begin : g_chk_p
      $error("PERIOD must be at least 2");
   end
   if (TW < 4) begin : g_chk_tw
      $error("TW must be at least 4");
   end

   logic [CW-1:0]                   cnt;
   logic                            wrap;
   logic [NB*SW-1:0]                cum_d, cum_q;
   logic                            err_d, err_q;
   logic                            empty_d, empty_q;
   logic [N_STATES*TRIP_W-1:0]      list_q;
   logic [SELW-1:0]                 sel;
   logic [TRIP_W-1:0]               level;

   sps_period_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap));

   sps_slot_plan #(.N_STATES(N_STATES), .TW(TW), .SW(SW)) u_plan (
      .tri_list(tri_list), .vec_tag(vec_tag), .on_time(on_time),
      .cum_flat(cum_d), .plan_err(err_d), .has_empty(empty_d));

   // shadow registers: new chain only at the period boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         list_q  <= '0;
         cum_q   <= '0;
         err_q   <= 1'b0;
         empty_q <= 1'b1;
      end else if (wrap) begin
         list_q  <= tri_list;
         cum_q   <= cum_d;
         err_q   <= err_d;
         empty_q <= empty_d;
      end
   end

   // slot index = number of slot ends already passed
   always_comb begin
      sel = '0;
      for (int k = 0; k < NB; k++)
         if (CMPW'(cnt) >= CMPW'(cum_q[k*SW +: SW])) sel = sel + 1'b1;
   end

   always_comb begin
      int st;
      st    = (int'(sel) < N_STATES) ? int'(sel) : (2 * N_STATES - 2 - int'(sel));
      level = list_q[TRIP_W*st +: TRIP_W];
   end

   sps_leg_map #(.NPH(PH)) u_map (.level(level), .gate(gate));

   assign seq_err = err_q;

   AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(list_q) |-> $past(wrap)); // R6

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $stable(seq_err)); // R7

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !err_q && !empty_q && level != $past(level))
         |-> one_step($past(level), level)); // R8

   AST_CLOSE_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !empty_q && int'(cum_q[(NB-1)*SW +: SW]) <= PERIOD - 1)
         |-> level == list_q[TRIP_W-1:0]); // R3

endmodule

// File: tb/tb_sps_sequencer.sv
module tb_sps_sequencer;

   localparam int CLK_P = 10;
   localparam int N     = 4;
   localparam int TW    = 12;
   localparam int P     = 100;
   localparam int S     = 2 * N - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N*6-1:0]  tri_list = '0;
   logic [N*2-1:0]  vec_tag = '0;
   logic [3*TW-1:0] on_time = '0;
   logic [5:0]      gate;
   logic            seq_err;

   int checks = 0;
   int fails  = 0;
   int ph     = 0;
   int toggles;
   logic [5:0] last_gate;

   logic [N*6-1:0]  cur_tri = '0;
   logic [N*2-1:0]  cur_tag = '0;
   logic [3*TW-1:0] cur_ot  = '0;
   logic            cur_err = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sps_sequencer #(.N_STATES(N), .TW(TW), .PERIOD(P)) dut (
      .clk(clk), .rst_n(rst_n), .tri_list(tri_list), .vec_tag(vec_tag),
      .on_time(on_time), .gate(gate), .seq_err(seq_err));

   function automatic logic [5:0] trip(int a, int b, int c);
      return {2'(c), 2'(b), 2'(a)};
   endfunction

   function automatic logic calc_err(logic [N*6-1:0] t, logic [N*2-1:0] g);
      logic e;
      e = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (g[2*i +: 2] == 2'd3) e = 1'b1;
         for (int p = 0; p < 3; p++) if (t[6*i + 2*p +: 2] == 2'd3) e = 1'b1;
      end
      for (int i = 0; i < N - 1; i++) begin
         int nd;
         nd = 0;
         for (int p = 0; p < 3; p++) begin
            int d;
            d = int'(t[6*i + 2*p +: 2]) - int'(t[6*(i+1) + 2*p +: 2]);
            if (d != 0) nd++;
            if (d > 1 || d < -1) e = 1'b1;
         end
         if (nd != 1) e = 1'b1;
      end
      return e;
   endfunction

   function automatic logic [5:0] exp_gate(int c);
      int mult [3];
      int dur [N];
      int start;
      int act;
      logic [5:0] g;
      for (int v = 0; v < 3; v++) mult[v] = 0;
      for (int i = 0; i < N; i++) begin
         int tg;
         tg = int'(cur_tag[2*i +: 2]);
         if (tg < 3) mult[tg] += (i == N - 1) ? 1 : 2;
      end
      for (int i = 0; i < N; i++) begin
         int tg;
         tg = int'(cur_tag[2*i +: 2]);
         dur[i] = (tg < 3 && mult[tg] > 0) ? int'(cur_ot[TW*tg +: TW]) / mult[tg] : 0;
      end
      start = 0;
      act   = -1;
      for (int j = 0; j < S; j++) begin
         int st;
         st = (j < N) ? j : 2 * N - 2 - j;
         if (act < 0 && (j == S - 1 || c < start + dur[st])) act = st;
         start += dur[st];
      end
      for (int p = 0; p < 3; p++) begin
         int lv;
         lv = int'(cur_tri[6*act + 2*p +: 2]);
         g[2*p + 1] = (lv >= 2);
         g[2*p]     = (lv >= 1);
      end
      return g;
   endfunction

   task automatic check(logic ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at phase %0d", req, act, exp, ph);
      end
   endtask

   // period phase and sampled chain as the requirements define them (R6)
   always @(posedge clk) begin
      if (!rst_n) begin
         ph      <= 0;
         cur_tri <= '0; cur_tag <= '0; cur_ot <= '0; cur_err <= 1'b0;
      end else if (ph == P - 1) begin
         ph      <= 0;
         cur_tri <= tri_list; cur_tag <= vec_tag; cur_ot <= on_time;
         cur_err <= calc_err(tri_list, vec_tag);
      end else begin
         ph <= ph + 1;
      end
   end

   task automatic apply(logic [5:0] s0, logic [5:0] s1, logic [5:0] s2, logic [5:0] s3,
                        logic [7:0] tg, int t0, int t1, int t2);
      tri_list = {s3, s2, s1, s0};
      vec_tag  = tg;
      on_time  = {TW'(t2), TW'(t1), TW'(t0)};
   endtask

   task automatic goto_start();
      do @(negedge clk); while (ph != 0);
   endtask

   // compares one full period, starting at the negedge of phase 0
   task automatic check_period(string req);
      toggles = 0;
      for (int c = 0; c < P; c++) begin
         logic [5:0] e;
         if (c != 0) @(negedge clk);
         e = exp_gate(ph);
         toggles += $countones(gate ^ last_gate);
         last_gate = gate;
         check(gate == e, req, int'(gate), int'(e));
         check(seq_err == cur_err, "R7", int'(seq_err), int'(cur_err));
      end
   endtask

   task automatic t_reset();
      apply(trip(1,1,0), trip(2,1,0), trip(2,2,0), trip(2,2,1), 8'b00_10_01_00, 30, 40, 30);
      repeat (3) @(negedge clk);
      check(gate == 6'd0, "R1", int'(gate), 0);
      check(seq_err == 1'b0, "R1", int'(seq_err), 0);
      rst_n = 1'b1;
      last_gate = gate;
      check_period("R1");
   endtask

   task automatic t_example();
      goto_start();
      check(gate == 6'b00_01_01, "R2", int'(gate), 6'b00_01_01);
      check_period("R3");
      check_period("R8");
      check(toggles == 6, "R8", toggles, 6);
   endtask

   task automatic t_rounding();
      apply(trip(1,0,0), trip(1,1,0), trip(1,1,1), trip(2,1,1), 8'b00_10_01_00, 31, 25, 17);
      goto_start();
      check_period("R4");
   endtask

   task automatic t_truncate();
      apply(trip(0,0,0), trip(1,0,0), trip(1,1,0), trip(1,1,1), 8'b00_10_01_00, 90, 90, 90);
      goto_start();
      check_period("R5");
   endtask

   task automatic t_errors();
      apply(trip(0,0,0), trip(2,0,0), trip(2,1,0), trip(2,1,1), 8'b00_10_01_00, 30, 30, 30);
      goto_start();
      check(seq_err == 1'b1, "R7", int'(seq_err), 1);
      check_period("R7");
      apply(trip(1,1,0), trip(2,2,0), trip(2,2,1), trip(2,2,2), 8'b00_10_01_00, 30, 30, 30);
      goto_start();
      check(seq_err == 1'b1, "R7", int'(seq_err), 1);
      check_period("R7");
      apply(trip(1,1,0), trip(2,1,0), trip(2,2,0), trip(2,2,1), 8'b11_10_01_00, 30, 30, 30);
      goto_start();
      check(seq_err == 1'b1, "R7", int'(seq_err), 1);
      check_period("R7");
      apply(trip(1,1,0), trip(2,1,0), trip(2,2,0), trip(2,2,1), 8'b00_10_01_00, 30, 40, 30);
      goto_start();
      check(seq_err == 1'b0, "R7", int'(seq_err), 0);
      check_period("R7");
   endtask

   task automatic t_latch();
      goto_start();
      for (int c = 0; c < P; c++) begin
         logic [5:0] e;
         if (c != 0) @(negedge clk);
         if (c == 40)
            apply(trip(0,1,1), trip(0,1,2), trip(0,2,2), trip(1,2,2), 8'b01_10_00_01, 20, 60, 20);
         e = exp_gate(ph);
         check(gate == e, "R6", int'(gate), int'(e));
      end
      @(negedge clk);
      check(ph == 0, "R6", ph, 0);
      last_gate = gate;
      check_period("R6");
   endtask

   initial begin
      t_reset();
      t_example();
      t_rounding();
      t_truncate();
      t_errors();
      t_latch();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule